// File: doc/BRIEF.md
# Video Stream and Timing Merge

This block joins a pixel stream (valid/ready handshake, with a start-of-frame flag and an end-of-line flag) to a raster timing reference produced elsewhere. The timing reference says which cycles carry an active pixel, which active pixel is the first of a frame and which one ends a line. While the stream is aligned with the timing, active cycles carry the incoming pixels. All other cycles carry a black value that is set separately for each color plane. The output is registered one cycle behind the timing inputs.

Alignment is gained by holding an incoming start-of-frame beat until the timing reference presents its first active pixel. Stream beats that arrive while no alignment exists and that carry no start-of-frame are taken and thrown away. Two faults end alignment: the stream having no beat when an active pixel is due, or the stream's frame or line boundaries falling away from the timing's boundaries. Either fault sends the block into a fallback state, which shows black or repeats the last good pixel as selected by a control input, and the block then waits for the next start-of-frame. The block also measures the size of the incoming frame and keeps wrapping event counters for locked frames, size errors and stalls.

Top module: `video_merge`

## Requirements
- R1: `vid_active_o` equals `tim_active_i` from one cycle earlier. A pixel shown from the stream appears on `vid_data_o` one cycle after its handshake.
- R2: In a cycle where `tim_active_i` is low, the next `vid_data_o` is black. Plane p of each pixel is `black_i[p*BPS +: BPS]`, and pixel k of the output word occupies bits `[k*NP*BPS +: NP*BPS]`.
- R3: Outside the locked state, a beat with `s_sof_i` high is accepted only in a cycle where `tim_sof_i` is high. Doing so shows that beat and enters the locked state. Beats without `s_sof_i` are accepted and discarded.
- R4: In the locked state, `s_ready_o` equals `tim_active_i`.
- R5: In the locked state, an active cycle with `s_valid_i` low increments `stall_cnt_o` and moves the block to the fallback state.
- R6: In the locked state, an active cycle with a valid beat whose `s_sof_i` differs from `tim_sof_i`, or whose `s_eol_i` differs from `tim_eol_i`, drops that beat. It also increments `size_err_cnt_o` and moves the block to the fallback state.
- R7: In an active cycle with no pixel shown, the output is black when `fallback_i` is 0 or the state is searching. It is the last shown pixel when `fallback_i` is 1 and the state is locked or fallback.
- R8: `locked_cnt_o` increments once for every shown beat that carries `s_sof_i`.
- R9: `status_o` encodes the state as 0 = searching, 1 = locked, 2 = fallback. The value 3 never appears.
- R10: At each accepted end-of-line beat, `vid_width_o` becomes (beats in that line) × PIP. At each accepted start-of-frame beat, `vid_height_o` becomes the number of end-of-line beats accepted since the previous start-of-frame.
- R11: After reset, the state is searching and every output register and counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | PIP*NP*BPS | Stream pixels |
| s_valid_i | input | 1 | Stream beat valid |
| s_sof_i | input | 1 | Beat is the first of a frame |
| s_eol_i | input | 1 | Beat is the last of a line |
| s_ready_o | output | 1 | Stream beat accepted |
| tim_active_i | input | 1 | Timing: active pixel cycle |
| tim_sof_i | input | 1 | Timing: first active pixel of frame |
| tim_eol_i | input | 1 | Timing: last active pixel of line |
| black_i | input | NP*BPS | Black value per plane |
| fallback_i | input | 1 | 0 = black on failure, 1 = repeat last pixel |
| vid_data_o | output | PIP*NP*BPS | Merged output pixels |
| vid_active_o | output | 1 | Output active flag |
| status_o | output | 2 | 0 searching, 1 locked, 2 fallback |
| vid_width_o | output | WW | Measured active width |
| vid_height_o | output | HW | Measured active height |
| locked_cnt_o | output | CW | Locked frame count |
| size_err_cnt_o | output | CW | Size error count |
| stall_cnt_o | output | CW | Stall count |

## Verification
A wrong state register shows up in `s_ready_o` during the same cycle. A locked block drops ready in blanking, while a searching block raises it for non-start beats. The same fault also appears on `vid_data_o` one cycle later, as black or held pixels where stream pixels belong. A missed fault detection leaves the status at 1 and the counters unchanged on the clock edge after the bad beat. A wrong measurement counter shows up in the width at the next end-of-line and in the height at the next start-of-frame. The bench tries every stream width and height around a fixed raster under both fallback modes, so every mismatch direction and the recovery path are covered.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH   = 2'd0,
    ST_LOCKED   = 2'd1,
    ST_FALLBACK = 2'd2
  } merge_state_e;
endpackage

// File: rtl/merge_ctrl.sv
module merge_ctrl
  import merge_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         s_valid_i,
  input  logic         s_sof_i,
  input  logic         s_eol_i,
  input  logic         tim_active_i,
  input  logic         tim_sof_i,
  input  logic         tim_eol_i,
  output logic         ready_o,
  output logic         show_o,
  output logic         stall_ev_o,
  output logic         err_ev_o,
  output logic         sof_ev_o,
  output merge_state_e state_o
);
  merge_state_e st_q;
  logic locked, mismatch, acq;

  always_comb begin
    locked     = (st_q == ST_LOCKED);
    mismatch   = (s_sof_i != tim_sof_i) || (s_eol_i != tim_eol_i);
    ready_o    = locked ? tim_active_i : (!s_sof_i || tim_sof_i);
    stall_ev_o = locked && tim_active_i && !s_valid_i;
    err_ev_o   = locked && tim_active_i && s_valid_i && mismatch;
    acq        = !locked && s_valid_i && s_sof_i && tim_sof_i;
    show_o     = (locked && tim_active_i && s_valid_i && !mismatch) || acq;
    sof_ev_o   = show_o && s_sof_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      st_q <= ST_SEARCH;
    else if (stall_ev_o || err_ev_o)  st_q <= ST_FALLBACK;
    else if (acq)                     st_q <= ST_LOCKED;
  end

  assign state_o = st_q;
endmodule

// File: rtl/merge_pixel.sv
module merge_pixel #(
  parameter int NP  = 3,
  parameter int BPS = 8,
  parameter int PIP = 1,
  localparam int PW = NP * BPS,
  localparam int DW = PIP * PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] s_data_i,
  input  logic          show_i,
  input  logic          tim_active_i,
  input  logic          hold_en_i,
  input  logic [PW-1:0] black_i,
  output logic [DW-1:0] vid_data_o,
  output logic          vid_active_o
);
  logic [DW-1:0] blk_rep, last_q;

  for (genvar k = 0; k < PIP; k++) begin : g_rep
    assign blk_rep[k*PW +: PW] = black_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_data_o   <= '0;
      vid_active_o <= 1'b0;
      last_q       <= '0;
    end else begin
      vid_active_o <= tim_active_i;
      if (show_i)                        vid_data_o <= s_data_i;
      else if (tim_active_i && hold_en_i) vid_data_o <= last_q;
      else                               vid_data_o <= blk_rep;
      if (show_i) last_q <= s_data_i;
    end
  end
endmodule

// File: rtl/merge_dims.sv
module merge_dims #(
  parameter int PIP = 1,
  parameter int WW  = 12,
  parameter int HW  = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hs_i,
  input  logic          sof_i,
  input  logic          eol_i,
  output logic [WW-1:0] width_o,
  output logic [HW-1:0] height_o
);
  logic [WW-1:0] col_q;
  logic [HW-1:0] lines_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      lines_q  <= '0;
      width_o  <= '0;
      height_o <= '0;
    end else if (hs_i) begin
      if (eol_i) begin
        width_o <= WW'((32'(col_q) + 1) * PIP);
        col_q   <= '0;
      end else begin
        col_q <= col_q + 1'b1;
      end
      if (sof_i) begin
        height_o <= lines_q;
        lines_q  <= HW'(eol_i);
      end else if (eol_i) begin
        lines_q <= lines_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/merge_counters.sv
module merge_counters #(
  parameter int N  = 3,
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         ev_i,
  output logic [N-1:0][CW-1:0] cnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_o[i] <= '0;
      else if (ev_i[i]) cnt_o[i] <= cnt_o[i] + 1'b1;
    end
  end
endmodule

// File: rtl/video_merge.sv
module video_merge
  import merge_pkg::*;
#(
  parameter int NP  = 3,
  parameter int BPS = 8,
  parameter int PIP = 1,
  parameter int WW  = 12,
  parameter int HW  = 12,
  parameter int CW  = 16,
  localparam int PW = NP * BPS,
  localparam int DW = PIP * PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_valid_i,
  input  logic          s_sof_i,
  input  logic          s_eol_i,
  output logic          s_ready_o,
  input  logic          tim_active_i,
  input  logic          tim_sof_i,
  input  logic          tim_eol_i,
  input  logic [PW-1:0] black_i,
  input  logic          fallback_i,
  output logic [DW-1:0] vid_data_o,
  output logic          vid_active_o,
  output logic [1:0]    status_o,
  output logic [WW-1:0] vid_width_o,
  output logic [HW-1:0] vid_height_o,
  output logic [CW-1:0] locked_cnt_o,
  output logic [CW-1:0] size_err_cnt_o,
  output logic [CW-1:0] stall_cnt_o
);
  merge_state_e        state;
  logic                show, stall_ev, err_ev, sof_ev, hold_en;
  logic [2:0][CW-1:0]  cnt;

  merge_ctrl u_ctrl (
    .clk_i, .rst_ni, .s_valid_i, .s_sof_i, .s_eol_i,
    .tim_active_i, .tim_sof_i, .tim_eol_i,
    .ready_o(s_ready_o), .show_o(show), .stall_ev_o(stall_ev),
    .err_ev_o(err_ev), .sof_ev_o(sof_ev), .state_o(state)
  );

  assign hold_en = fallback_i && (state != ST_SEARCH);

  merge_pixel #(.NP(NP), .BPS(BPS), .PIP(PIP)) u_pix (
    .clk_i, .rst_ni, .s_data_i, .show_i(show), .tim_active_i,
    .hold_en_i(hold_en), .black_i, .vid_data_o, .vid_active_o
  );

  merge_dims #(.PIP(PIP), .WW(WW), .HW(HW)) u_dims (
    .clk_i, .rst_ni, .hs_i(s_valid_i && s_ready_o), .sof_i(s_sof_i),
    .eol_i(s_eol_i), .width_o(vid_width_o), .height_o(vid_height_o)
  );

  merge_counters #(.N(3), .CW(CW)) u_cnt (
    .clk_i, .rst_ni, .ev_i({stall_ev, err_ev, sof_ev}), .cnt_o(cnt)
  );

  assign locked_cnt_o   = cnt[0];
  assign size_err_cnt_o = cnt[1];
  assign stall_cnt_o    = cnt[2];
  assign status_o       = state;
endmodule

// File: rtl/video_merge_chk.sv
module video_merge_chk #(
  parameter int NP  = 3,
  parameter int BPS = 8,
  parameter int PIP = 1,
  parameter int CW  = 16,
  localparam int PW = NP * BPS,
  localparam int DW = PIP * PW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s_valid_i,
  input logic          s_sof_i,
  input logic          s_ready_o,
  input logic          tim_active_i,
  input logic          tim_sof_i,
  input logic [PW-1:0] black_i,
  input logic [DW-1:0] vid_data_o,
  input logic          vid_active_o,
  input logic [1:0]    status_o,
  input logic [CW-1:0] size_err_cnt_o,
  input logic [CW-1:0] stall_cnt_o
);
  logic [DW-1:0] blk_rep;
  always_comb
    for (int k = 0; k < PIP; k++) blk_rep[k*PW +: PW] = black_i;

  assert_active_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> vid_active_o == $past(tim_active_i));

  assert_blank_black_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tim_active_i |=> vid_data_o == $past(blk_rep));

  assert_sof_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'd1 && s_sof_i && !tim_sof_i) |-> !s_ready_o);

  assert_locked_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'd1 |-> s_ready_o == tim_active_i);

  assert_stall_fallback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd1 && tim_active_i && !s_valid_i) |=>
      (status_o == 2'd2 && stall_cnt_o == CW'($past(stall_cnt_o) + 1'b1)));

  assert_sof_mismatch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd1 && tim_active_i && s_valid_i && (s_sof_i != tim_sof_i)) |=>
      (status_o == 2'd2 && size_err_cnt_o == CW'($past(size_err_cnt_o) + 1'b1)));

  assert_status_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'd3);
endmodule

bind video_merge video_merge_chk #(.NP(NP), .BPS(BPS), .PIP(PIP), .CW(CW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_valid_i(s_valid_i), .s_sof_i(s_sof_i),
  .s_ready_o(s_ready_o), .tim_active_i(tim_active_i), .tim_sof_i(tim_sof_i),
  .black_i(black_i), .vid_data_o(vid_data_o), .vid_active_o(vid_active_o),
  .status_o(status_o), .size_err_cnt_o(size_err_cnt_o), .stall_cnt_o(stall_cnt_o)
);

// File: tb/video_merge_tb_top.sv
module video_merge_tb_top;
  localparam int NP = 3, BPS = 8, PIP = 1, WW = 12, HW = 12, CW = 16;
  localparam int PW = NP * BPS, DW = PIP * PW;
  localparam int AW = 4, AH = 3, HT = 7, VT = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] s_data;
  logic          s_valid, s_sof, s_eol, s_ready;
  logic          tim_active, tim_sof, tim_eol;
  logic [PW-1:0] black;
  logic          fallback;
  logic [DW-1:0] vid_data;
  logic          vid_active;
  logic [1:0]    status;
  logic [WW-1:0] vid_width;
  logic [HW-1:0] vid_height;
  logic [CW-1:0] locked_cnt, size_err_cnt, stall_cnt;

  video_merge #(.NP(NP), .BPS(BPS), .PIP(PIP), .WW(WW), .HW(HW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .s_data_i(s_data), .s_valid_i(s_valid),
    .s_sof_i(s_sof), .s_eol_i(s_eol), .s_ready_o(s_ready),
    .tim_active_i(tim_active), .tim_sof_i(tim_sof), .tim_eol_i(tim_eol),
    .black_i(black), .fallback_i(fallback), .vid_data_o(vid_data),
    .vid_active_o(vid_active), .status_o(status), .vid_width_o(vid_width),
    .vid_height_o(vid_height), .locked_cnt_o(locked_cnt),
    .size_err_cnt_o(size_err_cnt), .stall_cnt_o(stall_cnt)
  );

  int n_cmp = 0, n_bad = 0;
  int rh, rv, sx, sy, sf, sw, sh, cyc, stall_at, n_tsof;
  int m_st, m_l, m_e, m_s, m_col, m_lines, m_w, m_h;
  logic [DW-1:0] m_last, e_data;
  bit e_act;
  string e_tag;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit ta, ts, te, sv, ss, se, lk, rdy, hs, mm, stl, err, acq, show;
    logic [DW-1:0] sd;
    ta = (rh < AW) && (rv < AH);
    ts = (rh == 0) && (rv == 0);
    te = ta && (rh == AW - 1);
    sv = (cyc != stall_at);
    ss = (sx == 0) && (sy == 0);
    se = (sx == sw - 1);
    sd = {8'(sf), 8'(sy), 8'(sx)};
    tim_active = ta; tim_sof = ts; tim_eol = te;
    s_valid = sv; s_sof = ss; s_eol = se; s_data = sd;
    #1;
    lk  = (m_st == 1);
    rdy = lk ? ta : (!ss || ts);
    chk(lk ? "R4" : "R3", 64'(s_ready), 64'(rdy));
    hs   = sv && rdy;
    mm   = (ss != ts) || (se != te);
    stl  = lk && ta && !sv;
    err  = lk && ta && sv && mm;
    acq  = !lk && sv && ss && ts;
    show = (lk && ta && sv && !mm) || acq;
    if (show)                            e_data = sd;
    else if (ta && fallback && m_st != 0) e_data = m_last;
    else                                 e_data = {PIP{black}};
    e_tag = show ? "R1" : (!ta ? "R2" : "R7");
    e_act = ta;
    if (show) m_last = sd;
    if (show && ss) m_l++;
    if (err) m_e++;
    if (stl) m_s++;
    if (stl || err) m_st = 2; else if (acq) m_st = 1;
    if (hs) begin
      if (se) begin m_w = (m_col + 1) * PIP; m_col = 0; end else m_col++;
      if (ss) begin m_h = m_lines; m_lines = se ? 1 : 0; end
      else if (se) m_lines++;
      if (se) begin
        sx = 0;
        if (sy == sh - 1) begin sy = 0; sf++; end else sy++;
      end else sx++;
    end
    if (ts) n_tsof++;
    rh++;
    if (rh == HT) begin rh = 0; rv = (rv + 1) % VT; end
    cyc++;
    @(negedge clk);
    chk(e_tag, 64'(vid_data), 64'(e_data));
    chk("R1", 64'(vid_active), 64'(e_act));
    chk("R9", 64'(status), 64'(m_st));
    chk("R8", 64'(locked_cnt), 64'(m_l));
    chk("R6", 64'(size_err_cnt), 64'(m_e));
    chk("R5", 64'(stall_cnt), 64'(m_s));
    chk("R10", 64'(vid_width), 64'(m_w));
    chk("R10", 64'(vid_height), 64'(m_h));
  endtask

  task automatic run(input int w, input int h, input bit fb, input int frames, input int stall_cyc);
    rst_n = 1'b0;
    s_valid = 0; s_sof = 0; s_eol = 0; s_data = '0;
    tim_active = 0; tim_sof = 0; tim_eol = 0;
    black = 24'h10_80_80 ^ 24'(w * 16 + h);
    fallback = fb;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11", 64'(status), 64'd0);
    chk("R11", 64'(vid_data), 64'd0);
    chk("R11", 64'(vid_active), 64'd0);
    chk("R11", 64'(locked_cnt | size_err_cnt | stall_cnt), 64'd0);
    chk("R11", 64'(vid_width | vid_height), 64'd0);
    sw = w; sh = h; stall_at = stall_cyc;
    rh = 0; rv = 2; sx = 0; sy = 1; sf = 0; cyc = 0; n_tsof = 0;
    m_st = 0; m_l = 0; m_e = 0; m_s = 0; m_col = 0; m_lines = 0; m_w = 0; m_h = 0;
    m_last = '0;
    for (int i = 0; i < frames * HT * VT; i++) step();
    // arithmetic end-of-run checks
    chk("R10", 64'(vid_width), 64'(w * PIP));
    chk("R10", 64'(vid_height), 64'(h));
    if (w == AW && h == AH) begin
      chk("R8", 64'(locked_cnt), 64'(n_tsof));
      chk("R6", 64'(size_err_cnt), 64'd0);
      chk("R5", 64'(stall_cnt), 64'(stall_cyc >= 0 ? 1 : 0));
      chk("R9", 64'(status), 64'd1);
    end else begin
      chk("R6", 64'(size_err_cnt != 0), 64'd1);
      chk("R5", 64'(stall_cnt), 64'd0);
    end
  endtask

  initial begin
    #1_500_000;
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int fb = 0; fb < 2; fb++)
      for (int w = 2; w <= 6; w++)
        for (int h = 2; h <= 4; h++)
          run(w, h, fb[0], 8, -1);
    // stall during a locked active pixel (raster line 1, pixel 1 of frame 2)
    run(AW, AH, 1'b0, 8, 29 + 2 * HT * VT);
    run(AW, AH, 1'b1, 8, 29 + 2 * HT * VT);
    run(AW, AH, 1'b1, 8, 30 + 4 * HT * VT);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule